// File: doc/BRIEF.md
# Next Program Counter Generator

This block holds the program counter of a small 8-bit controller with a 16-bit code address space. It works out the next counter value for every kind of control transfer the core supports, and it also produces a separate address for reading constant data out of code memory. Decode logic drives it with the current instruction's length, a target mode, the address fields taken from the instruction bytes, the accumulator and the data pointer. A condition resolver outside the block supplies a taken flag. When that flag is low, or the mode is plain sequential fetch, the counter moves past the instruction. When it is high, the counter loads the target for the selected mode.

All address arithmetic is 16 bits wide and wraps modulo 65536. A relative offset counts from the address of the following instruction, which is the counter plus the instruction length. An in-page target keeps the upper five bits of that same following address. An indexed code read adds the zero-extended accumulator to either the data pointer or the following address. Both outputs are registered. The counter only changes on cycles where the step input is high. The code-read address is refreshed on every cycle.

Top module: `pc_target_unit`

## Requirements
- R1: While `rst` is high, `pc_q` becomes 0000h and `code_addr` becomes 0000h at the next clock edge.
- R2: On a clock edge where `step` is low, `pc_q` keeps its value whatever the other inputs are.
- R3: On a step where `taken` is low, or where `mode` is 0 (sequential), `pc_q` becomes `pc_q + ilen` modulo 65536 (`ilen` is 1, 2 or 3). The value of `taken` has no effect in sequential mode.
- R4: On a taken step with `mode` = 1 (relative), `pc_q` becomes `pc_q + ilen + sext(rel_off)`, where `rel_off` is two's complement (−128..+127), modulo 65536.
- R5: On a taken step with `mode` = 2 (in-page), `pc_q` becomes bits 15:11 of `pc_q + ilen` joined with the 11-bit `page_field`. The page therefore follows the address after the instruction, even when that address has crossed a 2 KB boundary.
- R6: On a taken step with `mode` = 3 (long), `pc_q` becomes `long_addr`.
- R7: On a taken step with `mode` = 4 (indexed jump), `pc_q` becomes zero-extended `acc` plus `dptr`, modulo 65536.
- R8: On every edge out of reset, `code_addr` becomes zero-extended `acc` plus a base, modulo 65536. The base is `dptr` when `idx_from_pc` is 0, and `pc_q + ilen` when `idx_from_pc` is 1.
- R9: The `mode` values 5, 6 and 7 are reserved and act as sequential: a taken step with them gives `pc_q + ilen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Advance the program counter this cycle |
| taken | input | 1 | Transfer taken (ignored in sequential mode) |
| mode | input | 3 | Target mode: 0 seq, 1 relative, 2 in-page, 3 long, 4 indexed jump |
| ilen | input | 2 | Length of the current instruction in bytes (1..3) |
| rel_off | input | 8 | Signed relative offset |
| page_field | input | 11 | In-page target bits 10:0 |
| long_addr | input | 16 | Full destination address |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| idx_from_pc | input | 1 | Code-read base select: 0 data pointer, 1 following address |
| pc_q | output | 16 | Program counter |
| code_addr | output | 16 | Indexed code-read address |

## Verification
The assertions assume `ilen` is 1, 2 or 3 whenever `step` is high. A zero length is outside the contract, and the sequential-advance property would still pass with it even though the core would stall. They also assume that `mode`, `taken` and the address fields are stable from one cycle's sampling edge up to the edge that uses them. The stimulus holds to both. Every vector is applied on the falling edge with a legal length, including the pseudo-random phase, which maps its draw onto 1..3. Boundary vectors cover each wrap point: past FFFFh, a backward reach below 0000h, a page crossing caused only by the instruction length, and a full-scale accumulator added to a high data pointer.

// File: rtl/pcgen_pkg.sv
package pcgen_pkg;
  typedef enum logic [2:0] {
    TGT_SEQ   = 3'd0,
    TGT_REL   = 3'd1,
    TGT_PAGE  = 3'd2,
    TGT_LONG  = 3'd3,
    TGT_INDEX = 3'd4
  } tgt_mode_e;
endpackage

// File: rtl/pcgen_seq.sv
module pcgen_seq #(
  parameter int PC_W  = 16,
  parameter int LEN_W = 2
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [LEN_W-1:0] len,
  output logic [PC_W-1:0]  next_seq
);
  always_comb next_seq = pc + PC_W'(len);
endmodule

// File: rtl/pcgen_rel.sv
module pcgen_rel #(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8
) (
  input  logic [PC_W-1:0]   base,
  input  logic [DATA_W-1:0] offset,
  output logic [PC_W-1:0]   target
);
  localparam int EXT_W = PC_W - DATA_W;
  logic [PC_W-1:0] off_ext;
  always_comb begin
    off_ext = {{EXT_W{offset[DATA_W-1]}}, offset};
    target  = base + off_ext;
  end
endmodule

// File: rtl/pcgen_page.sv
module pcgen_page #(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 11
) (
  input  logic [PC_W-1:0]   base,
  input  logic [PAGE_W-1:0] field,
  output logic [PC_W-1:0]   target
);
  always_comb target = {base[PC_W-1:PAGE_W], field};
endmodule

// File: rtl/pcgen_index.sv
module pcgen_index #(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8
) (
  input  logic [PC_W-1:0]   base,
  input  logic [DATA_W-1:0] index,
  output logic [PC_W-1:0]   addr
);
  localparam int EXT_W = PC_W - DATA_W;
  always_comb addr = base + {{EXT_W{1'b0}}, index};
endmodule

// File: rtl/pc_target_unit.sv
module pc_target_unit
  import pcgen_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 11,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              taken,
  input  logic [2:0]        mode,
  input  logic [LEN_W-1:0]  ilen,
  input  logic [DATA_W-1:0] rel_off,
  input  logic [PAGE_W-1:0] page_field,
  input  logic [PC_W-1:0]   long_addr,
  input  logic [DATA_W-1:0] acc,
  input  logic [PC_W-1:0]   dptr,
  input  logic              idx_from_pc,
  output logic [PC_W-1:0]   pc_q,
  output logic [PC_W-1:0]   code_addr
);
  localparam int EXT_W = PC_W - DATA_W;

  tgt_mode_e       mode_e;
  logic [PC_W-1:0] after_instr;
  logic [PC_W-1:0] rel_tgt;
  logic [PC_W-1:0] page_tgt;
  logic [PC_W-1:0] jmp_idx_tgt;
  logic [PC_W-1:0] rd_base;
  logic [PC_W-1:0] rd_addr;
  logic [PC_W-1:0] pc_nxt;

  assign mode_e = tgt_mode_e'(mode);

  pcgen_seq #(.PC_W(PC_W), .LEN_W(LEN_W)) u_seq (
    .pc(pc_q), .len(ilen), .next_seq(after_instr));

  pcgen_rel #(.PC_W(PC_W), .DATA_W(DATA_W)) u_rel (
    .base(after_instr), .offset(rel_off), .target(rel_tgt));

  pcgen_page #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_page (
    .base(after_instr), .field(page_field), .target(page_tgt));

  pcgen_index #(.PC_W(PC_W), .DATA_W(DATA_W)) u_jidx (
    .base(dptr), .index(acc), .addr(jmp_idx_tgt));

  assign rd_base = idx_from_pc ? after_instr : dptr;

  pcgen_index #(.PC_W(PC_W), .DATA_W(DATA_W)) u_ridx (
    .base(rd_base), .index(acc), .addr(rd_addr));

  always_comb begin
    pc_nxt = after_instr;
    if (taken) begin
      unique case (mode_e)
        TGT_REL:   pc_nxt = rel_tgt;
        TGT_PAGE:  pc_nxt = page_tgt;
        TGT_LONG:  pc_nxt = long_addr;
        TGT_INDEX: pc_nxt = jmp_idx_tgt;
        default:   pc_nxt = after_instr;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      code_addr <= '0;
    end else begin
      if (step) pc_q <= pc_nxt;
      code_addr <= rd_addr;
    end
  end

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pc_q)); // R2

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step && (!taken || mode == 3'd0)) |=> pc_q == $past(pc_q) + PC_W'($past(ilen))); // R3

  AST_REL_REACH: assert property (@(posedge clk) disable iff (rst)
    (step && taken && mode == 3'd1) |=>
      pc_q == $past(pc_q) + PC_W'($past(ilen)) + {{EXT_W{$past(rel_off[DATA_W-1])}}, $past(rel_off)}); // R4

  AST_PAGE_LOW: assert property (@(posedge clk) disable iff (rst)
    (step && taken && mode == 3'd2) |=> pc_q[PAGE_W-1:0] == $past(page_field)); // R5

  AST_LONG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (step && taken && mode == 3'd3) |=> pc_q == $past(long_addr)); // R6

  AST_RSVD_SEQ: assert property (@(posedge clk) disable iff (rst)
    (step && taken && mode > 3'd4) |=> pc_q == $past(pc_q) + PC_W'($past(ilen))); // R9
endmodule

// File: tb/sim_pc_target_unit.sv
`timescale 1ns/1ps
module sim_pc_target_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0, taken = 1'b0, idx_from_pc = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [1:0]  ilen = 2'd1;
  logic [7:0]  rel_off = '0, acc = '0;
  logic [10:0] page_field = '0;
  logic [15:0] long_addr = '0, dptr = '0;
  logic [15:0] pc_q, code_addr;

  int tests = 0, fails = 0;
  int exp_pc = 0, exp_ca = 0;
  int seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  pc_target_unit u0 (
    .clk(clk), .rst(rst), .step(step), .taken(taken), .mode(mode),
    .ilen(ilen), .rel_off(rel_off), .page_field(page_field),
    .long_addr(long_addr), .acc(acc), .dptr(dptr),
    .idx_from_pc(idx_from_pc), .pc_q(pc_q), .code_addr(code_addr));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%04h expected=%04h", req, act, exp);
    end
  endtask

  function automatic string pc_req();
    if (!step) return "R2";
    if (!taken || mode == 3'd0) return "R3";
    case (mode)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R9";
    endcase
  endfunction

  // Behavioural model: predicts both registers from the inputs before the edge
  task automatic predict();
    int nxt, off;
    nxt = (exp_pc + ilen) % 65536;
    off = (rel_off >= 128) ? int'(rel_off) - 256 : int'(rel_off);
    exp_ca = (acc + (idx_from_pc ? nxt : int'(dptr))) % 65536;
    if (step && taken) begin
      case (mode)
        3'd1: nxt = (nxt + off + 65536) % 65536;
        3'd2: nxt = (nxt / 2048) * 2048 + page_field;
        3'd3: nxt = long_addr;
        3'd4: nxt = (acc + dptr) % 65536;
        default: ;
      endcase
    end
    if (step) exp_pc = nxt;
  endtask

  task automatic tick();
    string r;
    r = pc_req();
    predict();
    @(posedge clk);
    @(negedge clk);
    check(r, pc_q, exp_pc);
    check("R8", code_addr, exp_ca);
  endtask

  task automatic drive(input logic s, input logic t, input logic [2:0] m,
                       input logic [1:0] l);
    step = s; taken = t; mode = m; ilen = l;
    tick();
  endtask

  task automatic go_to(input logic [15:0] a);
    long_addr = a;
    drive(1'b1, 1'b1, 3'd3, 2'd3);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    long_addr = 16'hBEEF; step = 1'b1; taken = 1'b1; mode = 3'd3;
    @(posedge clk); @(negedge clk);
    check("R1", pc_q, 0);
    check("R1", code_addr, 0);
    rst = 1'b0;
    exp_pc = 0;

    // R3 sequential lengths; taken ignored in mode 0
    drive(1'b1, 1'b0, 3'd0, 2'd1);
    drive(1'b1, 1'b1, 3'd0, 2'd2);
    drive(1'b1, 1'b0, 3'd0, 2'd3);
    // R2 hold with a long target offered
    long_addr = 16'h4321;
    drive(1'b0, 1'b1, 3'd3, 2'd3);
    drive(1'b0, 1'b1, 3'd1, 2'd2);
    // R3 wrap past FFFF
    go_to(16'hFFFE);
    drive(1'b1, 1'b0, 3'd0, 2'd3);
    // R3 not-taken relative
    rel_off = 8'h40;
    drive(1'b1, 1'b0, 3'd1, 2'd2);
    // R4 reach limits and wrap below zero
    go_to(16'h1000); rel_off = 8'h7F; drive(1'b1, 1'b1, 3'd1, 2'd2);
    go_to(16'h1000); rel_off = 8'h80; drive(1'b1, 1'b1, 3'd1, 2'd2);
    go_to(16'h0000); rel_off = 8'h80; drive(1'b1, 1'b1, 3'd1, 2'd2);
    go_to(16'hFFF0); rel_off = 8'h20; drive(1'b1, 1'b1, 3'd1, 2'd3);
    // R5 in-page, including page crossing by length alone
    go_to(16'h3456); page_field = 11'h123; drive(1'b1, 1'b1, 3'd2, 2'd2);
    go_to(16'h07FE); page_field = 11'h005; drive(1'b1, 1'b1, 3'd2, 2'd2);
    go_to(16'hFFFF); page_field = 11'h7FF; drive(1'b1, 1'b1, 3'd2, 2'd2);
    // R6 long
    go_to(16'hA5C3);
    // R7 indexed jump with wrap
    acc = 8'h10; dptr = 16'h2000; drive(1'b1, 1'b1, 3'd4, 2'd1);
    acc = 8'hFF; dptr = 16'hFFF0; drive(1'b1, 1'b1, 3'd4, 2'd1);
    // R8 code read from data pointer and from following address
    idx_from_pc = 1'b0; acc = 8'h80; dptr = 16'hFF90; drive(1'b0, 1'b0, 3'd0, 2'd1);
    go_to(16'hFFFD); idx_from_pc = 1'b1; acc = 8'h05; drive(1'b0, 1'b0, 3'd0, 2'd3);
    // R9 reserved modes behave sequentially
    drive(1'b1, 1'b1, 3'd5, 2'd1);
    drive(1'b1, 1'b1, 3'd6, 2'd2);
    drive(1'b1, 1'b1, 3'd7, 2'd3);

    // mixed pseudo-random phase
    for (int i = 0; i < 300; i++) begin
      seed = seed * 1103515245 + 12345;
      rel_off = seed[15:8]; acc = seed[23:16];
      page_field = seed[26:16]; idx_from_pc = seed[5];
      seed = seed * 1103515245 + 12345;
      long_addr = seed[23:8]; dptr = seed[31:16];
      drive(seed[0] | seed[1], seed[2], seed[7:5], 2'(1 + (seed[4:3] % 3)));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule